// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus timing for an 8-bit processor whose low address byte and data byte share one set of pins. The core asks for one machine cycle at a time. There are five cycle kinds: opcode fetch, memory read, memory write, port read and port write. Each request carries a 16-bit address and, for writes, one data byte. The sequencer steps through T-states. It strobes the address latch enable, switches the shared bus between address and data, and drives the upper address byte, the active-low read and write strobes, the memory/port select and a two-bit status code.

A slow device holds READY low, and the sequencer inserts wait states for as long as it does. An external master raises HOLD to take the bus. The sequencer then finishes the cycle in progress, raises its acknowledge and floats its bus pins until HOLD falls. Read data is captured from the shared bus at the close of the last data state and handed back to the core with a one-cycle valid pulse. When the core issues a new request in the final T-state of a cycle, the next cycle follows without a gap.

Top module: `mux_bus_seq`

## Requirements
- R1: `ale` is high for exactly the first T-state (T1) of each machine cycle. In T1, `ad_oe` is high and `ad_out` carries the low address byte, while `rd_n` and `wr_n` are both high.
- R2: `a_hi_oe` is high and `a_hi` is held constant from T1 through the last T-state. For memory cycles `a_hi` is `req_addr[15:8]`. For port cycles both `a_hi` and the T1 low byte are the port number `req_addr[7:0]`.
- R3: An opcode fetch takes four T-states and the other kinds take three. In a fetch, `rd_n` is low in T2, in any wait states and in T3, and high again in T4. The shared bus is released (`ad_oe` low) whenever `rd_n` is low.
- R4: `req_kind` codes are 0 fetch, 1 memory read, 2 memory write, 3 port read and 4 port write. During a cycle `{s1,s0}` is 11 for a fetch, 10 for both reads and 01 for both writes. `iom` is 1 for port cycles and 0 for memory cycles. Outside a machine cycle, including straight after reset, `{s1,s0}` is 00 and `iom`, `ale`, `ad_oe` and `a_hi_oe` are 0, with both strobes high.
- R5: In the write kinds, `wr_n` is low in T2, in any wait states and in T3. Over those same states `ad_oe` is high and `ad_out` carries `req_wdata`, while `rd_n` stays high. `rd_n` and `wr_n` are never low together.
- R6: For the read kinds (codes 0, 1 and 3), `ad_in` is sampled on the clock edge that ends T3. `rdata` then shows that byte, and `rdata_valid` is high, for exactly the following clock cycle.
- R7: READY is sampled on the edge that ends T2 and on the edge that ends each wait state. Each low sample inserts one more wait state, and the strobe and bus drive of the data phase are held through every wait state.
- R8: When `hold` is high at the end of a cycle, or while the sequencer is idle, the next state is the hold state. In the hold state `hlda` is high and `ad_oe`, `a_hi_oe` and `ctl_oe` are low, and no request is accepted. `hlda` falls in the cycle after `hold` is sampled low, and the sequencer then returns to idle.
- R9: `req_accept` is high only while idle or in the final T-state, with `req_valid` high, a legal kind and `hold` low. T1 of the accepted cycle comes in the very next clock cycle, so a request taken in a final T-state starts with no idle cycle between the two machine cycles.
- R10: A request with `req_kind` 5, 6 or 7 is ignored. `req_accept` stays low and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_accept | output | 1 | Request taken this cycle |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | `rdata` valid this cycle |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | External master asks for the bus |
| hlda | output | 1 | Bus handed over |
| ale | output | 1 | Address latch enable |
| ad_out | output | 8 | Shared bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, incoming value |
| a_hi | output | 8 | Upper address byte |
| a_hi_oe | output | 1 | Upper address output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iom | output | 1 | 1 = port cycle, 0 = memory cycle |
| ctl_oe | output | 1 | Enable for `rd_n`, `wr_n` and `iom` |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The bench compares every pin on every clock against a per-T-state picture built from the requirements, so it checks each cycle's full length, not just its end. A fetch that is one state short, or a read that grows a fourth state, shifts every following picture. A READY sample taken in the wrong state changes the number of wait states. Two cycles chained in back-to-back final T-states expose a sequencer that drops through idle or fails to accept, and the port cycles catch an upper byte that still carries the real address. Holding the bus in mid-cycle shows whether the handover waits for the cycle boundary and whether requests leak through while `hlda` is high. The illegal codes show whether a bad kind starts a cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_TW   = 3'd3,
      TS_T3   = 3'd4,
      TS_T4   = 3'd5,
      TS_HOLD = 3'd6
   } tstate_e;

   localparam logic [2:0] KC_FETCH = 3'd0;
   localparam logic [2:0] KC_MRD   = 3'd1;
   localparam logic [2:0] KC_MWR   = 3'd2;
   localparam logic [2:0] KC_IORD  = 3'd3;
   localparam logic [2:0] KC_IOWR  = 3'd4;

   typedef struct packed {
      logic legal;
      logic long_cyc;
      logic is_read;
      logic is_wr;
      logic is_io;
      logic s1;
      logic s0;
   } cyc_attr_t;

endpackage

// File: rtl/mbs_kind_dec.sv
module mbs_kind_dec
   import mbs_pkg::*;
#(
   parameter int KIND_W = 3
) (
   input  logic [KIND_W-1:0] kind,
   output cyc_attr_t         attr
);

   initial begin : p_param_chk
      assert (KIND_W >= 3) else $fatal(1, "KIND_W must hold codes 0..4");
   end

   localparam int KPAD = KIND_W - 3;

   logic       hi_clear;
   logic [2:0] code;

   generate
      if (KPAD > 0) begin : g_wide
         assign hi_clear = (kind[KIND_W-1:3] == '0);
      end else begin : g_exact
         assign hi_clear = 1'b1;
      end
   endgenerate

   assign code = kind[2:0];

   always_comb begin
      attr = '0;
      if (hi_clear) begin
         case (code)
            KC_FETCH: attr = '{legal:1'b1, long_cyc:1'b1, is_read:1'b1, is_wr:1'b0,
                               is_io:1'b0, s1:1'b1, s0:1'b1};
            KC_MRD:   attr = '{legal:1'b1, long_cyc:1'b0, is_read:1'b1, is_wr:1'b0,
                               is_io:1'b0, s1:1'b1, s0:1'b0};
            KC_MWR:   attr = '{legal:1'b1, long_cyc:1'b0, is_read:1'b0, is_wr:1'b1,
                               is_io:1'b0, s1:1'b0, s0:1'b1};
            KC_IORD:  attr = '{legal:1'b1, long_cyc:1'b0, is_read:1'b1, is_wr:1'b0,
                               is_io:1'b1, s1:1'b1, s0:1'b0};
            KC_IOWR:  attr = '{legal:1'b1, long_cyc:1'b0, is_read:1'b0, is_wr:1'b1,
                               is_io:1'b1, s1:1'b0, s0:1'b1};
            default:  attr = '0;
         endcase
      end
   end

endmodule

// File: rtl/mbs_tstate_fsm.sv
module mbs_tstate_fsm
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  cyc_attr_t         in_attr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready,
   input  logic              hold,
   output tstate_e           st,
   output cyc_attr_t         cur_attr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              req_accept
);

   tstate_e st_nx;
   logic    at_boundary;
   logic    take;

   always_comb begin
      at_boundary = (st == TS_IDLE) || (st == TS_T4) ||
                    ((st == TS_T3) && !cur_attr.long_cyc);
   end

   assign take       = at_boundary && !hold && req_valid && in_attr.legal;
   assign req_accept = take;

   always_comb begin
      st_nx = st;
      case (st)
         TS_IDLE: begin
            if (hold)      st_nx = TS_HOLD;
            else if (take) st_nx = TS_T1;
         end
         TS_T1: st_nx = TS_T2;
         TS_T2, TS_TW: st_nx = ready ? TS_T3 : TS_TW;
         TS_T3, TS_T4: begin
            if ((st == TS_T3) && cur_attr.long_cyc) st_nx = TS_T4;
            else if (hold)                         st_nx = TS_HOLD;
            else if (take)                         st_nx = TS_T1;
            else                                   st_nx = TS_IDLE;
         end
         TS_HOLD: st_nx = hold ? TS_HOLD : TS_IDLE;
         default: st_nx = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= TS_IDLE;
         cur_attr  <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else begin
         st <= st_nx;
         if (take) begin
            cur_attr  <= in_attr;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
         end
      end
   end

   // R7
   wait_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == TS_T2 || st == TS_TW) && !ready) |=> (st == TS_TW));

   // R7
   wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == TS_T2 || st == TS_TW) && ready) |=> (st == TS_T3));

   // R3
   t4_after_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_T4) |-> ($past(st) == TS_T3));

   // R8
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_HOLD && $past(st) != TS_HOLD) |-> $past(hold));

   // R9
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |=> (st == TS_T1));

endmodule

// File: rtl/mbs_pin_drv.sv
module mbs_pin_drv
   import mbs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tstate_e           st,
   input  cyc_attr_t         cur_attr,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [DATA_W-1:0] cur_wdata,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] a_hi,
   output logic              a_hi_oe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              iom,
   output logic              ctl_oe,
   output logic              s1,
   output logic              s0,
   output logic              hlda,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid
);

   logic              in_cyc;
   logic              data_ph;
   logic              cap_now;
   logic [DATA_W-1:0] lo_byte;
   logic [DATA_W-1:0] hi_byte;

   assign in_cyc  = (st == TS_T1) || (st == TS_T2) || (st == TS_TW) ||
                    (st == TS_T3) || (st == TS_T4);
   assign data_ph = (st == TS_T2) || (st == TS_TW) || (st == TS_T3);
   assign cap_now = (st == TS_T3) && cur_attr.is_read;

   assign lo_byte = cur_addr[DATA_W-1:0];
   assign hi_byte = cur_attr.is_io ? cur_addr[DATA_W-1:0] : cur_addr[ADDR_W-1:DATA_W];

   assign ale     = (st == TS_T1);
   assign ad_oe   = (st == TS_T1) || (data_ph && cur_attr.is_wr);
   assign ad_out  = (st == TS_T1) ? lo_byte : cur_wdata;
   assign a_hi_oe = in_cyc;
   assign a_hi    = hi_byte;
   assign rd_n    = !(data_ph && cur_attr.is_read);
   assign wr_n    = !(data_ph && cur_attr.is_wr);
   assign iom     = in_cyc && cur_attr.is_io;
   assign s1      = in_cyc && cur_attr.s1;
   assign s0      = in_cyc && cur_attr.s0;
   assign hlda    = (st == TS_HOLD);
   assign ctl_oe  = !hlda;

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata       <= '0;
               rdata_valid <= 1'b0;
            end else begin
               rdata_valid <= cap_now;
               if (cap_now) rdata <= ad_in;
            end
         end
      end else begin : g_rd_pass
         assign rdata       = ad_in;
         assign rdata_valid = cap_now;
      end
   endgenerate

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R1
   ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R1
   ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && a_hi_oe && rd_n && wr_n));

   // R3
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R2
   hi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hi_oe && !ale) |-> ($stable(a_hi) && $past(a_hi_oe)));

   // R8
   hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ad_oe && !a_hi_oe && !ctl_oe));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int KIND_W    = 3,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [KIND_W-1:0] req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_accept,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid,
   input  logic              ready,
   input  logic              hold,
   output logic              hlda,
   output logic              ale,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] a_hi,
   output logic              a_hi_oe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              iom,
   output logic              ctl_oe,
   output logic              s1,
   output logic              s0
);

   initial begin : p_param_chk
      assert (ADDR_W == 2 * DATA_W) else $fatal(1, "ADDR_W must be twice DATA_W");
   end

   cyc_attr_t         in_attr;
   cyc_attr_t         cur_attr;
   tstate_e           st;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;

   mbs_kind_dec #(.KIND_W(KIND_W)) i_dec (
      .kind (req_kind),
      .attr (in_attr)
   );

   mbs_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .in_attr    (in_attr),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ready      (ready),
      .hold       (hold),
      .st         (st),
      .cur_attr   (cur_attr),
      .cur_addr   (cur_addr),
      .cur_wdata  (cur_wdata),
      .req_accept (req_accept)
   );

   mbs_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RDATA_REG(RDATA_REG)) i_drv (
      .clk         (clk),
      .rst_n       (rst_n),
      .st          (st),
      .cur_attr    (cur_attr),
      .cur_addr    (cur_addr),
      .cur_wdata   (cur_wdata),
      .ad_in       (ad_in),
      .ale         (ale),
      .ad_out      (ad_out),
      .ad_oe       (ad_oe),
      .a_hi        (a_hi),
      .a_hi_oe     (a_hi_oe),
      .rd_n        (rd_n),
      .wr_n        (wr_n),
      .iom         (iom),
      .ctl_oe      (ctl_oe),
      .s1          (s1),
      .s0          (s0),
      .hlda        (hlda),
      .rdata       (rdata),
      .rdata_valid (rdata_valid)
   );

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;

   localparam int P_IDLE = 0;
   localparam int P_T1   = 1;
   localparam int P_T2   = 2;
   localparam int P_TW   = 3;
   localparam int P_T3   = 4;
   localparam int P_T4   = 5;
   localparam int P_HOLD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        req_accept;
   logic [7:0]  rdata;
   logic        rdata_valid;
   logic        ready = 1'b1;
   logic        hold = 1'b0;
   logic        hlda;
   logic        ale;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  ad_in = 8'h0;
   logic [7:0]  a_hi;
   logic        a_hi_oe;
   logic        rd_n;
   logic        wr_n;
   logic        iom;
   logic        ctl_oe;
   logic        s1;
   logic        s0;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   mux_bus_seq i_mux_bus_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
      .rdata(rdata), .rdata_valid(rdata_valid), .ready(ready), .hold(hold),
      .hlda(hlda), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .a_hi(a_hi), .a_hi_oe(a_hi_oe), .rd_n(rd_n), .wr_n(wr_n), .iom(iom),
      .ctl_oe(ctl_oe), .s1(s1), .s0(s0)
   );

   typedef struct {
      logic [36:0] pins;
      string       tag;
   } snap_t;

   snap_t q[$];

   function automatic logic [36:0] pack(
      logic a_le, logic a_doe, logic [7:0] a_d, logic h_oe, logic [7:0] h,
      logic c_oe, logic r_n, logic w_n, logic io, logic st1, logic st0,
      logic hl, logic acc, logic rv, logic [7:0] rd);
      pack = {a_le, a_doe, (a_doe ? a_d : 8'h00), h_oe, (h_oe ? h : 8'h00),
              c_oe, (c_oe ? {r_n, w_n, io} : 3'b000), st1, st0, hl, acc, rv,
              (rv ? rd : 8'h00)};
   endfunction

   // Expected pin picture for one T-state, built from the requirements.
   function automatic snap_t mk(int ph, int k, logic [15:0] a, logic [7:0] wd,
                                logic acc, logic rv, logic [7:0] rd, string tag);
      logic       io, wr, e_ale, e_doe, e_hoe, e_coe, e_rn, e_wn, e_io, e_s1, e_s0, e_hl;
      logic [7:0] e_d, e_h;
      snap_t      s;
      io = (k == 3) || (k == 4);
      wr = (k == 2) || (k == 4);
      e_ale = 0; e_doe = 0; e_d = 0; e_hoe = 0; e_h = 0; e_coe = 1;
      e_rn = 1; e_wn = 1; e_io = 0; e_s1 = 0; e_s0 = 0; e_hl = 0;
      if (ph == P_HOLD) begin
         e_coe = 0; e_hl = 1;
      end else if (ph != P_IDLE) begin
         e_hoe = 1;
         e_h   = io ? a[7:0] : a[15:8];
         e_io  = io;
         e_s1  = (k == 0) || (k == 1) || (k == 3);
         e_s0  = (k == 0) || (k == 2) || (k == 4);
         if (ph == P_T1) begin
            e_ale = 1; e_doe = 1; e_d = a[7:0];
         end else if (ph != P_T4) begin
            if (wr) begin
               e_doe = 1; e_d = wd; e_wn = 0;
            end else begin
               e_rn = 0;
            end
         end
      end
      s.pins = pack(e_ale, e_doe, e_d, e_hoe, e_h, e_coe, e_rn, e_wn, e_io,
                    e_s1, e_s0, e_hl, acc, rv, rd);
      s.tag  = tag;
      return s;
   endfunction

   // Monitor: one expected picture per clock, compared mid-cycle.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         snap_t       e;
         logic [36:0] got;
         e   = q.pop_front();
         got = pack(ale, ad_oe, ad_out, a_hi_oe, a_hi, ctl_oe, rd_n, wr_n, iom,
                    s1, s0, hlda, req_accept, rdata_valid, rdata);
         n_vec++;
         if (got !== e.pins) begin
            n_bad++;
            $display("FAIL %s at %0t: pins got %h expected %h", e.tag, $time, got, e.pins);
         end
      end
   end

   int          nx_k = 0;
   logic [15:0] nx_a = 0;
   logic [7:0]  nx_wd = 0;

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      #1;
   endtask

   // Driver: issues one machine cycle and queues the picture of each T-state.
   task automatic do_cycle(int k, logic [15:0] a, logic [7:0] wd, int nw,
                           logic [7:0] rv, bit skip_idle, bit chain, bit hold_req,
                           string tag);
      bit read;
      read = (k == 0) || (k == 1) || (k == 3);
      if (!skip_idle) begin
         @(posedge clk); #2;
         req_valid = 1; req_kind = 3'(k); req_addr = a; req_wdata = wd;
         q.push_back(mk(P_IDLE, k, a, wd, 1'b1, 1'b0, 8'h0, tag));
      end
      @(posedge clk); #2;
      req_valid = 0; ready = (nw == 0);
      q.push_back(mk(P_T1, k, a, wd, 1'b0, 1'b0, 8'h0, tag));
      @(posedge clk); #2;
      if (hold_req) hold = 1;
      q.push_back(mk(P_T2, k, a, wd, 1'b0, 1'b0, 8'h0, tag));
      for (int w = 0; w < nw; w++) begin
         @(posedge clk); #2;
         if (w == nw - 1) ready = 1;
         q.push_back(mk(P_TW, k, a, wd, 1'b0, 1'b0, 8'h0, tag));
      end
      @(posedge clk); #2;
      ad_in = rv;
      if (k != 0 && chain) begin
         req_valid = 1; req_kind = 3'(nx_k); req_addr = nx_a; req_wdata = nx_wd;
      end
      q.push_back(mk(P_T3, k, a, wd, (k != 0) && chain, 1'b0, 8'h0, tag));
      if (k == 0) begin
         @(posedge clk); #2;
         if (chain) begin
            req_valid = 1; req_kind = 3'(nx_k); req_addr = nx_a; req_wdata = nx_wd;
         end
         q.push_back(mk(P_T4, k, a, wd, chain, 1'b1, rv, tag));
      end
      if (!chain) begin
         @(posedge clk); #2;
         q.push_back(mk(hold_req ? P_HOLD : P_IDLE, k, a, wd, 1'b0,
                        read && (k != 0), rv, tag));
         drain();
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R4: idle pin state straight after reset
      q.push_back(mk(P_IDLE, 0, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R4"));
      drain();

      // R3 R6: fetch, four states, byte returned in T4
      do_cycle(0, 16'h1234, 8'h00, 0, 8'h3E, 0, 0, 0, "R3");
      // R6 R4: memory read
      do_cycle(1, 16'hC200, 8'h00, 0, 8'h5A, 0, 0, 0, "R6");
      // R5: memory write
      do_cycle(2, 16'h8000, 8'hA5, 0, 8'h00, 0, 0, 0, "R5");
      // R2: port read, upper byte replaced by the port number
      do_cycle(3, 16'h7780, 8'h00, 0, 8'h39, 0, 0, 0, "R2");
      // R2 R5: port write
      do_cycle(4, 16'hFF41, 8'h3C, 0, 8'h00, 0, 0, 0, "R2");
      // R7: two wait states on a read, one on a fetch, three on a write
      do_cycle(1, 16'h2050, 8'h00, 2, 8'hC3, 0, 0, 0, "R7");
      do_cycle(0, 16'h0024, 8'h00, 1, 8'h7E, 0, 0, 0, "R7");
      do_cycle(4, 16'h0010, 8'h99, 3, 8'h00, 0, 0, 0, "R7");

      // R10: codes 5 and 7 must not start a cycle
      @(posedge clk); #2;
      req_valid = 1; req_kind = 3'd5; req_addr = 16'hABCD;
      q.push_back(mk(P_IDLE, 5, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R10"));
      @(posedge clk); #2;
      req_kind = 3'd7;
      q.push_back(mk(P_IDLE, 7, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R10"));
      @(posedge clk); #2;
      req_valid = 0;
      q.push_back(mk(P_IDLE, 0, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R10"));
      drain();

      // R8: hold raised in T2 of a write; cycle completes, then handover
      do_cycle(2, 16'h3170, 8'h5E, 0, 8'h00, 0, 0, 1, "R8");
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #2;
         req_valid = 1; req_kind = 3'd1; req_addr = 16'h4444;
         q.push_back(mk(P_HOLD, 1, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R8"));
      end
      @(posedge clk); #2;
      hold = 0; req_valid = 0;
      q.push_back(mk(P_HOLD, 1, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R8"));
      @(posedge clk); #2;
      q.push_back(mk(P_IDLE, 1, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, "R8"));
      drain();

      // R9: write, port write and fetch chained with no idle cycle between
      nx_k = 4; nx_a = 16'h0081; nx_wd = 8'h17;
      do_cycle(2, 16'hD000, 8'h42, 0, 8'h00, 0, 1, 0, "R9");
      nx_k = 0; nx_a = 16'h0100; nx_wd = 8'h00;
      do_cycle(4, 16'h0081, 8'h17, 0, 8'h00, 1, 1, 0, "R9");
      do_cycle(0, 16'h0100, 8'h00, 0, 8'hE6, 1, 0, 0, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule